// File: doc/BRIEF.md
# Priority Message Dispatch Controller

This block sits between a message network and a processing node and decides when a message handler starts. Message words arrive one per cycle, each with a priority bit and a tail flag, and are stored in one of two per-priority queues. Every queue entry is a slot of `LEN` words. A message can be dispatched once its tail word has been stored. When the node is idle, the oldest complete message of the highest non-empty priority is dispatched. While a low-priority handler runs, a complete high-priority message preempts it, but only if interrupts are enabled.

On dispatch the block pulses `start`. It presents the handler's instruction pointer, which is taken from the low bits of the message's first word, and a message pointer that addresses the message's slot. The handler reads its words through `rd_addr`/`rd_data` at offsets from that pointer. A `suspend` strobe ends the running handler and frees its slot. If a low-priority handler had been preempted, it becomes the running task again with its own pointers restored. Translating the opcode and switching register files are left to neighbouring logic.

Top module: `msg_dispatch`

## Requirements
- R1: Each priority has its own queue of `SLOTS` message slots. `in_ready[p]` falls in the cycle after the tail that completes the `SLOTS`-th message held in queue p. It rises again in the cycle after a suspend retires a message from that queue. The other queue's ready bit is not affected.
- R2: A message is never dispatched before its tail word has been accepted, however many of its words are already stored.
- R3: From idle, if a tail word is accepted at clock edge k, `start` is high for exactly one cycle, beginning at edge k+3. If both queues hold complete messages, the high-priority (1) message is dispatched first.
- R4: At dispatch, `ip` equals bits [IP_W-1:0] of the message's first word, and `mp` equals {priority, slot, LEN_W zero bits}, where slots are used in turn 0, 1, … per priority. `rd_data` returns the stored word at `rd_addr`, so word j of the message is at `mp + j`.
- R5: A complete high-priority message preempts a running low-priority handler only while `int_en` is 1; with `int_en` at 1 it starts three edges after its tail edge. Nothing starts while a high-priority handler runs.
- R6: `suspend` retires the running handler's message. If a preempted low-priority handler exists, the next cycle shows `busy`=1, `run_prio`=0 and that handler's `ip` and `mp`, with no `start` pulse. Otherwise `busy` falls.
- R7: Within one priority, messages are dispatched in arrival order.
- R8: `suspend` while no handler is active changes nothing: the ready bits and the slot order stay as they were.
- R9: Words beyond the `LEN`-th of a message are discarded, and the message's tail still completes it.
- R10: After reset, `busy`=0, `start`=0 and `in_ready`=2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message word valid |
| in_prio | input | 1 | Priority of the incoming word (0 low, 1 high) |
| in_word | input | W | Incoming message word |
| in_tail | input | 1 | Marks the last word of a message |
| in_ready | output | 2 | Per-priority queue can accept words |
| suspend | input | 1 | Running handler ends; retire its message |
| int_en | input | 1 | Preemption allowed |
| start | output | 1 | One-cycle pulse when a handler is dispatched |
| busy | output | 1 | A handler is running |
| run_prio | output | 1 | Priority of the running handler |
| ip | output | IP_W | Instruction pointer of the running handler |
| mp | output | 1+log2(SLOTS)+log2(LEN) | Message pointer of the running handler |
| rd_addr | input | 1+log2(SLOTS)+log2(LEN) | Handler read address into message storage |
| rd_data | output | W | Stored word at rd_addr |

## Verification
The bench uses the default values: W=16, IP_W=12, SLOTS=2, LEN=4. With only two slots per priority, one running message plus one waiting message is enough to fill a queue, so backpressure and slot wrap-around are reached within a few messages. A four-word slot lets a six-word message test the discard of overflow words. A 12-bit pointer taken from 16-bit words shows that the upper opcode bits are truncated.

// File: rtl/msg_dispatch.sv
module msg_dispatch #(
  parameter int W     = 16,
  parameter int IP_W  = 12,
  parameter int SLOTS = 2,
  parameter int LEN   = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LEN_W  = $clog2(LEN),
  localparam int MP_W   = 1 + SLOT_W + LEN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_prio,
  input  logic [W-1:0]    in_word,
  input  logic            in_tail,
  output logic [1:0]      in_ready,
  input  logic            suspend,
  input  logic            int_en,
  output logic            start,
  output logic            busy,
  output logic            run_prio,
  output logic [IP_W-1:0] ip,
  output logic [MP_W-1:0] mp,
  input  logic [MP_W-1:0] rd_addr,
  output logic [W-1:0]    rd_data
);
  localparam logic [SLOT_W:0] FULL  = SLOTS[SLOT_W:0];
  localparam logic [LEN_W:0]  LEN_L = LEN[LEN_W:0];

  logic [W-1:0]      mem [2**MP_W];
  logic [SLOT_W-1:0] wp [2];
  logic [SLOT_W-1:0] rp [2];
  logic [SLOT_W:0]   cnt [2];
  logic [LEN_W:0]    widx [2];
  logic [IP_W-1:0]   ip_r [2];
  logic [MP_W-1:0]   mp_r [2];
  logic              lo_act, hi_act, tgt, start_r;
  logic [1:0]        lat;

  logic acc, want_hi, want_lo;
  logic [1:0] push_t, pop_v;
  logic [MP_W-1:0] head_addr, wr_addr;

  assign in_ready  = {cnt[1] < FULL, cnt[0] < FULL};
  assign acc       = in_valid && in_ready[in_prio];
  assign push_t    = {acc && in_tail && in_prio, acc && in_tail && !in_prio};
  assign pop_v     = {suspend && hi_act, suspend && lo_act && !hi_act};
  assign want_hi   = (cnt[1] != '0) && !hi_act && (!lo_act || int_en);
  assign want_lo   = (cnt[0] != '0) && !lo_act && !hi_act;
  assign head_addr = {tgt, rp[tgt], {LEN_W{1'b0}}};
  assign wr_addr   = {in_prio, wp[in_prio], widx[in_prio][LEN_W-1:0]};

  assign start    = start_r;
  assign busy     = hi_act || lo_act;
  assign run_prio = hi_act;
  assign ip       = hi_act ? ip_r[1] : ip_r[0];
  assign mp       = hi_act ? mp_r[1] : mp_r[0];
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk)
    if (acc && widx[in_prio] < LEN_L) mem[wr_addr] <= in_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        wp[p]   <= '0;
        rp[p]   <= '0;
        cnt[p]  <= '0;
        widx[p] <= '0;
        ip_r[p] <= '0;
        mp_r[p] <= '0;
      end
      lo_act  <= 1'b0;
      hi_act  <= 1'b0;
      tgt     <= 1'b0;
      lat     <= 2'd0;
      start_r <= 1'b0;
    end else begin
      start_r <= 1'b0;
      for (int p = 0; p < 2; p++) begin
        if (acc && (in_prio == p[0])) begin
          if (in_tail)                widx[p] <= '0;
          else if (widx[p] < LEN_L)   widx[p] <= widx[p] + 1'b1;
        end
        if (push_t[p]) wp[p] <= wp[p] + 1'b1;
        if (pop_v[p])  rp[p] <= rp[p] + 1'b1;
        case ({push_t[p], pop_v[p]})
          2'b10:   cnt[p] <= cnt[p] + 1'b1;
          2'b01:   cnt[p] <= cnt[p] - 1'b1;
          default: ;
        endcase
      end
      if (pop_v[1]) hi_act <= 1'b0;
      if (pop_v[0]) lo_act <= 1'b0;

      if (lat == 2'd0) begin
        if (want_hi) begin
          lat <= 2'd1;
          tgt <= 1'b1;
        end else if (want_lo) begin
          lat <= 2'd1;
          tgt <= 1'b0;
        end
      end else if (lat == 2'd2) begin
        lat          <= 2'd0;
        start_r      <= 1'b1;
        ip_r[tgt]    <= mem[head_addr][IP_W-1:0];
        mp_r[tgt]    <= head_addr;
        if (tgt) hi_act <= 1'b1;
        else     lo_act <= 1'b1;
      end else begin
        lat <= lat + 1'b1;
      end
    end
  end
endmodule

module chk_msg_dispatch #(parameter int MP_W = 4) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            run_prio,
  input logic            suspend,
  input logic            in_valid,
  input logic            in_tail,
  input logic            in_prio,
  input logic [1:0]      in_ready,
  input logic [MP_W-1:0] mp,
  input logic            lo_act
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R3
  AST_NO_START_UNDER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_prio && !suspend) |=> !start); // R5
  AST_RESUME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && busy && run_prio && lo_act) |=> (busy && !run_prio)); // R6
  AST_LO_FULL_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready[0]) |-> $past(in_valid && in_tail && !in_prio)); // R1
  AST_HI_FULL_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready[1]) |-> $past(in_valid && in_tail && in_prio)); // R1
  AST_MP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mp[MP_W-1] == run_prio)); // R4
  AST_IDLE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && suspend && !in_valid) |=> $stable(in_ready)); // R8
endmodule

bind msg_dispatch chk_msg_dispatch #(.MP_W(MP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .run_prio(run_prio),
  .suspend(suspend), .in_valid(in_valid), .in_tail(in_tail), .in_prio(in_prio),
  .in_ready(in_ready), .mp(mp), .lo_act(lo_act)
);

// File: tb/test_msg_dispatch.sv
module test_msg_dispatch;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_prio = 0, in_tail = 0, suspend = 0, int_en = 1;
  logic [15:0] in_word = 0;
  logic [1:0]  in_ready;
  logic        start, busy, run_prio;
  logic [11:0] ip;
  logic [3:0]  mp, rd_addr = 0;
  logic [15:0] rd_data;

  int nchk = 0, nfail = 0, cyc = 0;
  int wslot[2] = '{0, 0};
  int last_slot;

  always #2 clk = ~clk;

  msg_dispatch i_msg_dispatch (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit p, input int n, input logic [15:0] w0, input bit tail);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_prio = p; in_word = w0 + 16'(i); in_tail = tail && (i == n - 1);
      @(negedge clk);
    end
    in_valid = 0; in_tail = 0;
    if (tail) begin
      last_slot = wslot[p];
      wslot[p] = (wslot[p] + 1) % 2;
    end
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!start && n < 10) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_suspend;
    suspend = 1;
    @(negedge clk);
    suspend = 0;
  endtask

  task automatic idle_cycles(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (start) seen = 1;
    end
  endtask

  function automatic logic [3:0] exp_mp(input bit p, input int slot);
    return {p, slot[0], 2'b00};
  endfunction

  task automatic t_reset;
    check("R10 busy", busy, 0);
    check("R10 start", start, 0);
    check("R10 in_ready", in_ready, 2'b11);
  endtask

  task automatic t_idle_dispatch;
    int n; bit seen;
    send(0, 2, 16'hA123, 0);
    idle_cycles(5, seen);
    check("R2 no start before tail", seen, 0);
    check("R2 busy before tail", busy, 0);
    send(0, 1, 16'hA125, 1);
    wait_start(n);
    check("R3 idle latency", n, 3);
    check("R4 ip", ip, 12'h123);
    check("R4 mp", mp, exp_mp(0, last_slot));
    rd_addr = mp + 4'd1; #1;
    check("R4 word1", rd_data, 16'hA124);
    rd_addr = mp + 4'd2; #1;
    check("R4 word2", rd_data, 16'hA125);
    @(negedge clk);
    check("R3 start one cycle", start, 0);
  endtask

  task automatic t_preempt;
    int n; bit seen; int s;
    int_en = 0;
    send(1, 2, 16'hB456, 1);
    s = last_slot;
    idle_cycles(6, seen);
    check("R5 no preempt when disabled", seen, 0);
    check("R5 low still running", run_prio, 0);
    int_en = 1;
    wait_start(n);
    check("R5 preempt after enable", start, 1);
    check("R5 run_prio", run_prio, 1);
    check("R4 hi ip", ip, 12'h456);
    check("R4 hi mp", mp, exp_mp(1, s));
    do_suspend();
    check("R6 resume busy", busy, 1);
    check("R6 resume prio", run_prio, 0);
    check("R6 resume ip", ip, 12'h123);
    check("R6 resume mp", mp, exp_mp(0, 0));
    check("R6 no start on resume", start, 0);
    send(1, 3, 16'h7789, 1);
    s = last_slot;
    wait_start(n);
    check("R5 preempt latency", n, 3);
    check("R4 hi2 mp", mp, exp_mp(1, s));
    check("R4 hi2 ip", ip, 12'h789);
    do_suspend();
    check("R6 resume again", run_prio, 0);
    do_suspend();
    check("R6 idle after low suspend", busy, 0);
  endtask

  task automatic t_idle_suspend;
    int n;
    do_suspend();
    check("R8 busy", busy, 0);
    check("R8 in_ready", in_ready, 2'b11);
    send(0, 1, 16'h1ABC, 1);
    wait_start(n);
    check("R8 slot order kept", mp, exp_mp(0, last_slot));
    check("R8 ip", ip, 12'hABC);
    do_suspend();
  endtask

  task automatic t_backpressure_fifo;
    int n; bit seen; int sd;
    send(0, 1, 16'h0C01, 1);
    wait_start(n);
    check("R7 first ip", ip, 12'hC01);
    send(0, 2, 16'h0D02, 1);
    sd = last_slot;
    check("R1 low full", in_ready[0], 0);
    check("R1 high unaffected", in_ready[1], 1);
    idle_cycles(4, seen);
    check("R7 no same-prio preempt", seen, 0);
    do_suspend();
    check("R1 ready after retire", in_ready[0], 1);
    wait_start(n);
    check("R7 second latency", n, 3);
    check("R7 second ip", ip, 12'hD02);
    check("R7 second mp", mp, exp_mp(0, sd));
    do_suspend();
  endtask

  task automatic t_both_queued;
    int n; bit seen; int sb, sh;
    int_en = 0;
    send(0, 1, 16'h0A0A, 1);
    wait_start(n);
    send(0, 1, 16'h0B0B, 1); sb = last_slot;
    send(1, 1, 16'h0E0E, 1); sh = last_slot;
    idle_cycles(4, seen);
    check("R5 held off", seen, 0);
    do_suspend();
    wait_start(n);
    check("R3 high first latency", n, 3);
    check("R3 high first prio", run_prio, 1);
    check("R3 high first ip", ip, 12'hE0E);
    check("R4 high mp", mp, exp_mp(1, sh));
    do_suspend();
    wait_start(n);
    check("R7 low next ip", ip, 12'hB0B);
    check("R7 low next mp", mp, exp_mp(0, sb));
    do_suspend();
    int_en = 1;
  endtask

  task automatic t_overlong;
    int n;
    send(0, 6, 16'h3300, 1);
    wait_start(n);
    check("R9 dispatched", n, 3);
    rd_addr = mp + 4'd3; #1;
    check("R9 word3 kept", rd_data, 16'h3303);
    rd_addr = mp; #1;
    check("R9 word0 kept", rd_data, 16'h3300);
    do_suspend();
    check("R9 idle after", busy, 0);
    check("R9 queue empty", in_ready, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_dispatch();
    t_preempt();
    t_idle_suspend();
    t_backpressure_fifo();
    t_both_queued();
    t_overlong();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end
endmodule